// File: doc/BRIEF.md
# Three-Bank Rotating Activation Store

This block holds the neuron activations for an annealing network that learns from examples. It has three physical banks. Each bank keeps two copies of every activation: a clamped copy, taken while inputs and outputs are both held at the target pattern, and a free copy, taken while only the inputs are held. At any time each bank plays one of three roles. The next bank is being filled by the host. The current bank is being annealed. The last bank is being read by the weight updater. Loading, annealing and weight update therefore run at the same time on three different patterns.

Each user has its own port, and the block steers that port to whichever physical bank holds the user's role. A rotate request moves every role one step around the ring, so that no data has to be copied. A rotation is held back until all three users report that they are idle. The bank that each role points to is visible at the outputs. The lowest addresses hold the network inputs. The anneal port may not overwrite them, and an attempt to do so raises a sticky error flag.

For recall, the host writes test inputs into the free side of the next bank. After one rotation that bank is annealed. After a second rotation the host reads the results from the free side of the last bank.

Top module: `act_bank_ring`

## Requirements
- R1: While reset is held and just after it, physical bank 0 is current, bank 1 is next and bank 2 is last. `err_clamp` and `rot_done` are 0.
- R2: A rotation moves the roles like this: the old next bank becomes current, the old current bank becomes last, and the old last bank becomes next. `rot_done` is 1 for the cycle that follows the edge where the pointers change.
- R3: A rotate request waits until `idle_host`, `idle_ann` and `idle_upd` are all 1 at the same edge. Until then the request is remembered, even if `rot_req` has since dropped, and the pointers do not change.
- R4: The three role pointers always name three different banks in the range 0 to 2.
- R5: A host write stores data in the bank that holds the next role. The side bit selects the copy: 0 is the clamped copy and 1 is the free copy.
- R6: The anneal read port returns, one cycle after the address is given, the selected side (0 clamped, 1 free) of the current bank.
- R7: An anneal write at an address of `N_IN` (default 32) or higher updates the selected side of the current bank.
- R8: An anneal write at an address below `N_IN` is dropped on both sides. It sets `err_clamp` at the next edge, and `err_clamp` stays 1 until reset.
- R9: The updater port returns the clamped and free copies of the last bank at one address together, one cycle after the address is given.
- R10: The host read port returns the selected side (0 clamped, 1 free) of the last bank one cycle after the address is given.
- R11: A host write and an anneal write in the same cycle to the same address and side land in their own banks and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write enable (to the next bank) |
| host_side | input | 1 | Host write side, 0 clamped / 1 free |
| host_waddr | input | AW | Host write address |
| host_wdata | input | DW | Host write data |
| host_raddr | input | AW | Host read address (last bank) |
| host_rside | input | 1 | Host read side |
| host_rdata | output | DW | Host read data, one cycle latency |
| ann_we | input | 1 | Anneal write enable (current bank) |
| ann_side | input | 1 | Anneal write side |
| ann_waddr | input | AW | Anneal write address |
| ann_wdata | input | DW | Anneal write data |
| ann_raddr | input | AW | Anneal read address |
| ann_rside | input | 1 | Anneal read side |
| ann_rdata | output | DW | Anneal read data, one cycle latency |
| upd_raddr | input | AW | Updater read address (last bank) |
| upd_clamp_data | output | DW | Clamped copy at the updater address |
| upd_free_data | output | DW | Free copy at the updater address |
| rot_req | input | 1 | Request to advance the roles |
| idle_host | input | 1 | Host side is idle |
| idle_ann | input | 1 | Anneal side is idle |
| idle_upd | input | 1 | Updater side is idle |
| rot_done | output | 1 | One-cycle pulse after a rotation |
| ptr_next | output | 2 | Physical bank that holds the next role |
| ptr_cur | output | 2 | Physical bank that holds the current role |
| ptr_last | output | 2 | Physical bank that holds the last role |
| err_clamp | output | 1 | Sticky flag: anneal write to an input address |

## Verification
The host fills the clamped and free sides with two different address-dependent patterns, while the anneal port writes a third pattern to the same addresses of another bank. Reading these back tells a misrouted bank or side apart from a correct one. Three full rotations are followed by reads through every port, which shows whether the role pointers move in the stated cycle order and come back to the reset mapping. A request made while one user is busy, and then released later, separates a rotation that is wrongly dropped or wrongly taken early from one that is correctly deferred. Anneal writes to input addresses on both sides, followed by read-back, show whether the guard drops the data and whether the error flag stays set.

// File: rtl/act_ring_pkg.sv
package act_ring_pkg;

   typedef logic [1:0] bank_idx_t;

   typedef struct packed {
      bank_idx_t nxt;
      bank_idx_t cur;
      bank_idx_t lst;
   } role_map_t;

   localparam role_map_t ROLE_MAP_RESET = '{nxt: 2'd1, cur: 2'd0, lst: 2'd2};

   // One step around the ring: next -> current -> last -> next
   function automatic role_map_t role_advance(input role_map_t m);
      role_map_t r;
      r.cur = m.nxt;
      r.lst = m.cur;
      r.nxt = m.lst;
      return r;
   endfunction

endpackage

// File: rtl/act_ring_roles.sv
module act_ring_roles
   import act_ring_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rot_req,
   input  logic      idle_host,
   input  logic      idle_ann,
   input  logic      idle_upd,
   output role_map_t map_o,
   output logic      rot_done_o
);

   role_map_t map_q;
   logic      pend_q;
   logic      done_q;
   logic      all_idle;
   logic      fire;

   always_comb begin
      all_idle = idle_host & idle_ann & idle_upd;
      fire     = (rot_req | pend_q) & all_idle;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q  <= ROLE_MAP_RESET;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fire;
         pend_q <= (pend_q | rot_req) & ~fire;
         if (fire) map_q <= role_advance(map_q);
      end
   end

   assign map_o      = map_q;
   assign rot_done_o = done_q;

endmodule

// File: rtl/act_ring_bank.sv
module act_ring_bank #(
   parameter  int DW    = 5,
   parameter  int DEPTH = 160,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic          wside,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_addr,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] ra_clamp,
   output logic [DW-1:0] ra_free,
   output logic [DW-1:0] rb_clamp,
   output logic [DW-1:0] rb_free
);

   logic wr_in_range;
   logic ra_in_range;
   logic rb_in_range;

   always_comb begin
      wr_in_range = (32'(waddr)   < DEPTH);
      ra_in_range = (32'(ra_addr) < DEPTH);
      rb_in_range = (32'(rb_addr) < DEPTH);
   end

   // side 0 = clamped copy, side 1 = free copy
   for (genvar s = 0; s < 2; s++) begin : g_side
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] qa;
      logic [DW-1:0] qb;

      always_ff @(posedge clk) begin
         if (we && (wside == 1'(s)) && wr_in_range) mem[waddr] <= wdata;
         qa <= ra_in_range ? mem[ra_addr] : '0;
         qb <= rb_in_range ? mem[rb_addr] : '0;
      end
   end

   assign ra_clamp = g_side[0].qa;
   assign ra_free  = g_side[1].qa;
   assign rb_clamp = g_side[0].qb;
   assign rb_free  = g_side[1].qb;

endmodule

// File: rtl/act_bank_ring.sv
module act_bank_ring
   import act_ring_pkg::*;
#(
   parameter  int DW          = 5,
   parameter  int DEPTH       = 160,
   parameter  int N_IN        = 32,
   parameter  bit INPUT_GUARD = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_side,
   input  logic [AW-1:0] host_waddr,
   input  logic [DW-1:0] host_wdata,
   input  logic [AW-1:0] host_raddr,
   input  logic          host_rside,
   output logic [DW-1:0] host_rdata,
   input  logic          ann_we,
   input  logic          ann_side,
   input  logic [AW-1:0] ann_waddr,
   input  logic [DW-1:0] ann_wdata,
   input  logic [AW-1:0] ann_raddr,
   input  logic          ann_rside,
   output logic [DW-1:0] ann_rdata,
   input  logic [AW-1:0] upd_raddr,
   output logic [DW-1:0] upd_clamp_data,
   output logic [DW-1:0] upd_free_data,
   input  logic          rot_req,
   input  logic          idle_host,
   input  logic          idle_ann,
   input  logic          idle_upd,
   output logic          rot_done,
   output logic [1:0]    ptr_next,
   output logic [1:0]    ptr_cur,
   output logic [1:0]    ptr_last,
   output logic          err_clamp
);

   localparam int NB = 3;

   // elaboration-time parameter checks
   if (DW < 1) begin : g_bad_dw
      $error("act_bank_ring: DW must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("act_bank_ring: DEPTH must be at least 2");
   end
   if ((N_IN < 0) || (N_IN > DEPTH)) begin : g_bad_nin
      $error("act_bank_ring: N_IN must lie in 0..DEPTH");
   end

   role_map_t map;
   logic      ann_block;
   logic      err_q;
   bank_idx_t cur_d;
   bank_idx_t last_d;
   logic      ann_rside_d;
   logic      host_rside_d;

   logic [DW-1:0] a_clamp [NB];
   logic [DW-1:0] a_free  [NB];
   logic [DW-1:0] b_clamp [NB];
   logic [DW-1:0] b_free  [NB];

   act_ring_roles u_roles (
      .clk        (clk),
      .rst_n      (rst_n),
      .rot_req    (rot_req),
      .idle_host  (idle_host),
      .idle_ann   (idle_ann),
      .idle_upd   (idle_upd),
      .map_o      (map),
      .rot_done_o (rot_done)
   );

   // input-address guard on the anneal write port
   if (INPUT_GUARD) begin : g_guard
      assign ann_block = ann_we && (32'(ann_waddr) < N_IN);
   end else begin : g_noguard
      assign ann_block = 1'b0;
   end

   for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam bank_idx_t ID = bank_idx_t'(b);
      logic          is_nxt;
      logic          is_cur;
      logic          we;
      logic          wside;
      logic [AW-1:0] waddr;
      logic [DW-1:0] wdata;
      logic [AW-1:0] ra_addr;

      always_comb begin
         is_nxt  = (map.nxt == ID);
         is_cur  = (map.cur == ID);
         we      = 1'b0;
         wside   = host_side;
         waddr   = host_waddr;
         wdata   = host_wdata;
         if (is_nxt) begin
            we = host_we;
         end else if (is_cur) begin
            we    = ann_we & ~ann_block;
            wside = ann_side;
            waddr = ann_waddr;
            wdata = ann_wdata;
         end
         ra_addr = is_cur ? ann_raddr : upd_raddr;
      end

      act_ring_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
         .clk      (clk),
         .we       (we),
         .wside    (wside),
         .waddr    (waddr),
         .wdata    (wdata),
         .ra_addr  (ra_addr),
         .rb_addr  (host_raddr),
         .ra_clamp (a_clamp[b]),
         .ra_free  (a_free[b]),
         .rb_clamp (b_clamp[b]),
         .rb_free  (b_free[b])
      );
   end

   // remember which bank and side each read came from, for the output mux
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q        <= 1'b0;
         cur_d        <= ROLE_MAP_RESET.cur;
         last_d       <= ROLE_MAP_RESET.lst;
         ann_rside_d  <= 1'b0;
         host_rside_d <= 1'b0;
      end else begin
         err_q        <= err_q | ann_block;
         cur_d        <= map.cur;
         last_d       <= map.lst;
         ann_rside_d  <= ann_rside;
         host_rside_d <= host_rside;
      end
   end

   function automatic logic [DW-1:0] pick3(input logic [DW-1:0] v0,
                                           input logic [DW-1:0] v1,
                                           input logic [DW-1:0] v2,
                                           input bank_idx_t     s);
      case (s)
         2'd0:    return v0;
         2'd1:    return v1;
         2'd2:    return v2;
         default: return '0;
      endcase
   endfunction

   always_comb begin
      ann_rdata      = ann_rside_d
                     ? pick3(a_free[0],  a_free[1],  a_free[2],  cur_d)
                     : pick3(a_clamp[0], a_clamp[1], a_clamp[2], cur_d);
      upd_clamp_data = pick3(a_clamp[0], a_clamp[1], a_clamp[2], last_d);
      upd_free_data  = pick3(a_free[0],  a_free[1],  a_free[2],  last_d);
      host_rdata     = host_rside_d
                     ? pick3(b_free[0],  b_free[1],  b_free[2],  last_d)
                     : pick3(b_clamp[0], b_clamp[1], b_clamp[2], last_d);
   end

   assign ptr_next  = map.nxt;
   assign ptr_cur   = map.cur;
   assign ptr_last  = map.lst;
   assign err_clamp = err_q;

endmodule

// File: rtl/act_bank_ring_chk.sv
module act_bank_ring_chk #(
   parameter int AW   = 8,
   parameter int N_IN = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    ptr_next,
   input logic [1:0]    ptr_cur,
   input logic [1:0]    ptr_last,
   input logic          rot_done,
   input logic          idle_host,
   input logic          idle_ann,
   input logic          idle_upd,
   input logic          ann_we,
   input logic [AW-1:0] ann_waddr,
   input logic          err_clamp
);

   assert_roles_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_next != ptr_cur) && (ptr_cur != ptr_last) && (ptr_next != ptr_last) &&
      (ptr_next < 2'd3) && (ptr_cur < 2'd3) && (ptr_last < 2'd3));

   assert_rotation_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rot_done |-> (ptr_cur == $past(ptr_next)) && (ptr_last == $past(ptr_cur)) &&
                   (ptr_next == $past(ptr_last)));

   assert_move_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_cur != $past(ptr_cur)) |-> $past(idle_host && idle_ann && idle_upd));

   assert_done_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rot_done |-> $past(idle_host && idle_ann && idle_upd));

   assert_guard_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ann_we && (32'(ann_waddr) < N_IN)) |=> err_clamp);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_clamp |=> err_clamp);

endmodule

bind act_bank_ring act_bank_ring_chk #(.AW(AW), .N_IN(N_IN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr_next  (ptr_next),
   .ptr_cur   (ptr_cur),
   .ptr_last  (ptr_last),
   .rot_done  (rot_done),
   .idle_host (idle_host),
   .idle_ann  (idle_ann),
   .idle_upd  (idle_upd),
   .ann_we    (ann_we),
   .ann_waddr (ann_waddr),
   .err_clamp (err_clamp)
);

// File: tb/act_bank_ring_bench.sv
`timescale 1ns/1ps
module act_bank_ring_bench;

   localparam int DW = 5;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_we, host_side, host_rside;
   logic [AW-1:0] host_waddr, host_raddr;
   logic [DW-1:0] host_wdata, host_rdata;
   logic          ann_we, ann_side, ann_rside;
   logic [AW-1:0] ann_waddr, ann_raddr;
   logic [DW-1:0] ann_wdata, ann_rdata;
   logic [AW-1:0] upd_raddr;
   logic [DW-1:0] upd_clamp_data, upd_free_data;
   logic          rot_req, idle_host, idle_ann, idle_upd, rot_done, err_clamp;
   logic [1:0]    ptr_next, ptr_cur, ptr_last;

   always #4 clk = ~clk;

   act_bank_ring u_act_bank_ring (.*);

   typedef struct {
      int    due;
      int    port;
      int    exp;
      string tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_tests = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int fc(int i); return (i * 3 + 1) % 32; endfunction
   function automatic int gf(int i); return (i * 7 + 2) % 32; endfunction
   function automatic int ha(int i); return (i + 13) % 32;    endfunction
   function automatic int kf(int i); return (i * 5 + 4) % 32; endfunction

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_map(string tag, int n, int c, int l);
      check({tag, " next"}, ptr_next, n);
      check({tag, " cur"},  ptr_cur,  c);
      check({tag, " last"}, ptr_last, l);
   endtask

   // driver side of the scoreboard: port 0 anneal, 1 upd clamp, 2 upd free, 3 host
   task automatic expect_rd(int port, int exp, string tag);
      sb.push_back('{due: cyc + 1, port: port, exp: exp, tag: tag});
   endtask

   task automatic tick();
      @(negedge clk);
      host_we = 1'b0;
      ann_we  = 1'b0;
      rot_req = 1'b0;
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due == cyc) begin
         item_t it;
         int    act;
         it = sb.pop_front();
         case (it.port)
            0:       act = ann_rdata;
            1:       act = upd_clamp_data;
            2:       act = upd_free_data;
            default: act = host_rdata;
         endcase
         check(it.tag, act, it.exp);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      host_we = 0; host_side = 0; host_waddr = 0; host_wdata = 0;
      host_raddr = 0; host_rside = 0;
      ann_we = 0; ann_side = 0; ann_waddr = 0; ann_wdata = 0;
      ann_raddr = 0; ann_rside = 0; upd_raddr = 0;
      rot_req = 0; idle_host = 1; idle_ann = 1; idle_upd = 1;
      repeat (3) @(negedge clk);
      check_map("R1 in reset", 1, 0, 2);
      check("R1 err", err_clamp, 0);
      check("R1 done", rot_done, 0);
      rst_n = 1'b1;
      tick();
      check_map("R1 after reset", 1, 0, 2);

      // host fills the next bank (1), clamped side
      for (int i = 0; i < 45; i++) begin
         tick(); host_we = 1; host_side = 0; host_waddr = AW'(i); host_wdata = DW'(fc(i));
      end
      // free side; anneal writes bank 0 at the same addresses (R11)
      for (int i = 0; i < 45; i++) begin
         tick(); host_we = 1; host_side = 1; host_waddr = AW'(i); host_wdata = DW'(gf(i));
         if (i >= 40) begin
            ann_we = 1; ann_side = 1; ann_waddr = AW'(i); ann_wdata = DW'(ha(i));
         end
      end
      for (int i = 40; i < 45; i++) begin
         tick(); ann_raddr = AW'(i); ann_rside = 1;
         expect_rd(0, ha(i), "R7 R11 anneal readback current bank");
      end

      // deferred rotation (R3)
      tick(); idle_ann = 0; rot_req = 1;
      tick(); check_map("R3 held", 1, 0, 2); check("R3 no done", rot_done, 0);
      tick(); check_map("R3 still held", 1, 0, 2);
      tick(); idle_ann = 1;
      tick(); check("R2 done pulse", rot_done, 1); check_map("R2 first rotation", 2, 1, 0);
      tick(); check("R2 done one cycle", rot_done, 0);

      // current = bank 1 (host data), last = bank 0 (anneal data)
      for (int i = 0; i < 45; i++) begin
         tick(); ann_raddr = AW'(i); ann_rside = i[0];
         expect_rd(0, i[0] ? gf(i) : fc(i), "R5 R6 anneal reads host pattern");
         if (i >= 40) begin
            upd_raddr = AW'(i);
            expect_rd(2, ha(i), "R9 R11 updater free of last bank");
            host_raddr = AW'(i); host_rside = 1;
            expect_rd(3, ha(i), "R10 host read of last bank");
         end
      end

      // input guard (R8) and writable region (R7)
      tick(); check("R8 err clear", err_clamp, 0);
      ann_we = 1; ann_side = 0; ann_waddr = 3; ann_wdata = DW'(~fc(3));
      tick(); check("R8 err set", err_clamp, 1);
      ann_we = 1; ann_side = 1; ann_waddr = 10; ann_wdata = DW'(~gf(10));
      tick(); ann_we = 1; ann_side = 1; ann_waddr = 50; ann_wdata = DW'(ha(50));
      tick(); ann_raddr = 3; ann_rside = 0; expect_rd(0, fc(3), "R8 clamped input kept");
      tick(); ann_raddr = 10; ann_rside = 1; expect_rd(0, gf(10), "R8 free input kept");
      tick(); ann_raddr = 50; ann_rside = 1; expect_rd(0, ha(50), "R7 write above inputs");

      // host fills next bank 2, then second rotation
      for (int i = 0; i < 4; i++) begin
         tick(); host_we = 1; host_side = 0; host_waddr = AW'(i); host_wdata = DW'(kf(i));
      end
      tick(); rot_req = 1;
      tick(); check("R2 done second", rot_done, 1); check_map("R2 second rotation", 0, 2, 1);
      ann_raddr = 2; ann_rside = 0; expect_rd(0, kf(2), "R5 next bank became current");
      upd_raddr = 7;
      expect_rd(1, fc(7), "R9 updater clamp pair");
      expect_rd(2, gf(7), "R9 updater free pair");
      host_raddr = 7; host_rside = 0; expect_rd(3, fc(7), "R10 host read clamp side");

      // third rotation returns to the reset mapping
      tick(); rot_req = 1;
      tick(); check_map("R2 third rotation", 1, 0, 2);
      ann_raddr = 41; ann_rside = 1; expect_rd(0, ha(41), "R6 bank 0 current again");

      repeat (3) tick();
      check("R8 err sticky", err_clamp, 1);
      check("scoreboard drained", sb.size(), 0);
      finish_run();
   end

endmodule